// File: doc/BRIEF.md
# Prioritised Wake Controller

This block is always-on logic that keeps watching a bank of wake lines while the main processor sleeps. The lines can be general-purpose pins, a real-time-clock tick, a line that shows activity on a serial link, or the output of an analog comparator. Each line passes through its own debounce filter. Software configures each line separately: whether it is enabled, whether it triggers on a rising edge or on a high level, how long the line must be stable, and how many qualifying events must add up before a wake is raised. This pre-qualification lets routine events such as periodic ticks go by without waking the core until enough of them have arrived.

When a line qualifies, the block sets that line's bit in a sticky cause vector. It asserts a wake request while any cause bit is set. It also reports the resume level. The core should come back at full performance if any recorded source belongs to the urgent class, such as an over-temperature alarm. If only routine sources are recorded, the core should come back at a low-power operating point. Software reads the cause vector to find the source and clears bits with write-one-to-clear pulses.

Top module: `wake_arbiter`

## Requirements
- R1: While reset is held, and on the first cycle after it, `cause`, `wake_req` and `resume_full` are all zero.
- R2: A line's filtered value takes the raw value only after the raw value has differed from it on `db_len` consecutive clock edges, where a `db_len` of 0 counts as 1. A pulse shorter than that has no effect on `cause`.
- R3: In edge mode (`src_level` bit = 0), each rising edge of the filtered line is one event.
- R4: In level mode (`src_level` bit = 1), every cycle in which the filtered line is high is one event.
- R5: A source whose `src_en` bit is 0 never sets its cause bit, and its event count is reset to zero.
- R6: An enabled source sets its cause bit on its Tth event since its count was last reset, where T is its `qual_thresh` field (bits [i*CNT_W +: CNT_W]) and a T of 0 counts as 1. The count then restarts from zero.
- R7: Cause bits are sticky. A bit clears only on a cycle when the matching `cause_clr` bit is 1. If a new event and a clear arrive in the same cycle, the bit stays set.
- R8: `wake_req` is 1 exactly when at least one cause bit is set. Sources that qualify in the same cycle are all recorded.
- R9: `resume_full` is 1 exactly when at least one set cause bit has its `src_urgent` bit at 1. Otherwise a wake resumes at the low-power point.
- R10: For an enabled edge-mode source with threshold 1, a raw rise that is held from clock edge k is visible in `cause` after edge k+`db_len`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on slow clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wake_in | input | N_SRC | Raw wake lines, synchronous to clk |
| src_en | input | N_SRC | Per-source enable |
| src_level | input | N_SRC | Per-source trigger: 1 level-high, 0 rising edge |
| src_urgent | input | N_SRC | Per-source class: 1 full performance, 0 low power |
| db_len | input | N_SRC*DB_W | Per-source debounce length in cycles |
| qual_thresh | input | N_SRC*CNT_W | Per-source event count needed to wake |
| cause_clr | input | N_SRC | Write-one-to-clear pulses for cause bits |
| cause | output | N_SRC | Sticky wake cause vector |
| wake_req | output | 1 | Wake request to the power sequencer |
| resume_full | output | 1 | Resume at full performance when 1 |

## Verification
The assertions assume that the wake lines and configuration inputs are already synchronous to the slow clock and that reset is held for at least one edge. They also assume that a clear pulse lasts exactly the cycles on which software means to clear. The stimulus meets these conditions: it changes every input one time unit after a rising edge and holds it for whole cycles. It also changes configuration only between edges, so a threshold or debounce length never changes in the middle of a sampled cycle.

// File: rtl/wk_pkg.sv
// Shared types for the wake controller.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package wk_pkg;
    typedef enum logic {
        TRIG_EDGE  = 1'b0,
        TRIG_LEVEL = 1'b1
    } trig_e;
endpackage

// File: rtl/wk_debounce.sv
// Per-line debounce filter. The filtered output takes the raw value only
// after the raw value has differed from it on LEN consecutive edges
// (a LEN of 0 behaves as 1).
// Assumes: raw is synchronous to clk.
module wk_debounce #(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             raw,
    input  logic [LEN_W-1:0] len,
    output logic             filt
);
    logic [LEN_W-1:0] run;
    logic [LEN_W-1:0] eff_len;
    logic [LEN_W:0]   run_inc;

    // Effective length and next run value
    always_comb begin
        eff_len = (len == '0) ? LEN_W'(1) : len;
        run_inc = {1'b0, run} + 1'b1;
    end

    // Count consecutive disagreeing samples; flip filt when enough
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run  <= '0;
            filt <= 1'b0;
        end else if (raw == filt) begin
            run <= '0;
        end else if (run_inc >= {1'b0, eff_len}) begin
            filt <= raw;
            run  <= '0;
        end else begin
            run <= run_inc[LEN_W-1:0];
        end
    end

    // R2: the filter only ever moves toward the sampled raw value
    assert_filt_follows_raw_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (filt != $past(filt)) |-> ($past(raw) == filt));
endmodule

// File: rtl/wk_qualify.sv
// Event pre-qualifier. It counts events for one source and fires on the
// THRESH-th event (a THRESH of 0 behaves as 1). The count then restarts.
// Assumes: en low means the source is off; the count is reset.
module wk_qualify #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             event_in,
    input  logic [CNT_W-1:0] thresh,
    output logic             fire
);
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] eff_th;
    logic [CNT_W:0]   count_inc;

    // Decide whether this event reaches the threshold
    always_comb begin
        eff_th    = (thresh == '0) ? CNT_W'(1) : thresh;
        count_inc = {1'b0, count} + 1'b1;
        fire      = en && event_in && (count_inc >= {1'b0, eff_th});
    end

    // Advance or restart the event count
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            count <= '0;
        end else if (event_in) begin
            count <= fire ? '0 : count_inc[CNT_W-1:0];
        end
    end

    // R6: after a qualifying event the count restarts from zero
    assert_restart_after_fire_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(fire) |-> (count == '0));
endmodule

// File: rtl/wake_arbiter.sv
// Prioritised wake controller. Each source is debounced, turned into
// events (edge or level), pre-qualified by an event count, and then
// latched into a sticky cause vector. The wake request and the resume
// level are derived from the cause vector and the per-source class.
// Assumes: all inputs are synchronous to the always-on clock.
module wake_arbiter #(
    parameter int N_SRC = 8,
    parameter int DB_W  = 4,
    parameter int CNT_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_SRC-1:0]       wake_in,
    input  logic [N_SRC-1:0]       src_en,
    input  logic [N_SRC-1:0]       src_level,
    input  logic [N_SRC-1:0]       src_urgent,
    input  logic [N_SRC*DB_W-1:0]  db_len,
    input  logic [N_SRC*CNT_W-1:0] qual_thresh,
    input  logic [N_SRC-1:0]       cause_clr,
    output logic [N_SRC-1:0]       cause,
    output logic                   wake_req,
    output logic                   resume_full
);
    import wk_pkg::*;

    logic [N_SRC-1:0] filt;
    logic [N_SRC-1:0] filt_q;
    logic [N_SRC-1:0] evt;
    logic [N_SRC-1:0] fire;

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        wk_debounce #(.LEN_W(DB_W)) u_db (
            .clk  (clk),
            .rst_n(rst_n),
            .raw  (wake_in[i]),
            .len  (db_len[i*DB_W +: DB_W]),
            .filt (filt[i])
        );

        // Turn the filtered line into events according to its trigger mode
        always_comb begin
            if (trig_e'(src_level[i]) == TRIG_LEVEL) evt[i] = filt[i];
            else                                     evt[i] = filt[i] & ~filt_q[i];
        end

        wk_qualify #(.CNT_W(CNT_W)) u_q (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (src_en[i]),
            .event_in(evt[i]),
            .thresh  (qual_thresh[i*CNT_W +: CNT_W]),
            .fire    (fire[i])
        );
    end

    // Previous filtered value for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) filt_q <= '0;
        else        filt_q <= filt;
    end

    // Sticky cause vector; a new event wins over a clear
    always_ff @(posedge clk) begin
        if (!rst_n) cause <= '0;
        else        cause <= (cause & ~cause_clr) | fire;
    end

    // Wake request and resume level from the recorded causes
    always_comb begin
        wake_req    = |cause;
        resume_full = |(cause & src_urgent);
    end

    // R7: a cause bit falls only when software cleared it
    assert_cause_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(cause) & ~cause & ~$past(cause_clr)) == '0));

    // R5: a cause bit rises only for a source that was enabled
    assert_disabled_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((cause & ~$past(cause) & ~$past(src_en)) == '0));

    // R9: a full-performance resume is never signalled without a wake
    assert_full_needs_wake_R9: assert property (@(posedge clk) disable iff (!rst_n)
        resume_full |-> wake_req);
endmodule

// File: tb/wake_arbiter_tb_top.sv
module wake_arbiter_tb_top;
    localparam int N = 8;
    localparam int DW = 4;
    localparam int CW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] wake_in = '0, src_en = '0, src_level = '0, src_urgent = '0, cause_clr = '0;
    logic [N*DW-1:0] db_len = '0;
    logic [N*CW-1:0] qual_thresh = '0;
    logic [N-1:0] cause;
    logic wake_req, resume_full;

    int errors = 0;
    int checks = 0;
    string cur_req = "R1";
    bit done = 0;

    always #2 clk = ~clk;

    wake_arbiter dut_i (
        .clk(clk), .rst_n(rst_n), .wake_in(wake_in), .src_en(src_en),
        .src_level(src_level), .src_urgent(src_urgent), .db_len(db_len),
        .qual_thresh(qual_thresh), .cause_clr(cause_clr), .cause(cause),
        .wake_req(wake_req), .resume_full(resume_full)
    );

    // Behavioural reference model
    bit m_filt[N];
    bit m_prev[N];
    bit m_cause[N];
    int m_run[N];
    int m_cnt[N];

    always @(posedge clk) begin : model
        bit ev, fr;
        int len, th;
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                m_filt[i] = 0; m_prev[i] = 0; m_cause[i] = 0; m_run[i] = 0; m_cnt[i] = 0;
            end
        end else begin
            for (int i = 0; i < N; i++) begin
                ev = src_level[i] ? m_filt[i] : (m_filt[i] && !m_prev[i]);
                th = int'(qual_thresh[i*CW +: CW]);
                if (th == 0) th = 1;
                fr = src_en[i] && ev && (m_cnt[i] + 1 >= th);
                if (!src_en[i]) m_cnt[i] = 0;
                else if (ev) m_cnt[i] = fr ? 0 : m_cnt[i] + 1;
                if (fr) m_cause[i] = 1;
                else if (cause_clr[i]) m_cause[i] = 0;
                m_prev[i] = m_filt[i];
                len = int'(db_len[i*DW +: DW]);
                if (len == 0) len = 1;
                if (wake_in[i] == m_filt[i]) m_run[i] = 0;
                else if (m_run[i] + 1 >= len) begin m_filt[i] = wake_in[i]; m_run[i] = 0; end
                else m_run[i] = m_run[i] + 1;
            end
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Compare against the model on every cycle (covers R3 R4 R6 R7 R8 R9 per phase)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [N-1:0] ec;
            bit ew, ef;
            ew = 0; ef = 0;
            for (int i = 0; i < N; i++) begin
                ec[i] = m_cause[i];
                if (m_cause[i]) ew = 1;
                if (m_cause[i] && src_urgent[i]) ef = 1;
            end
            chk(cur_req, "cause vs model", int'(cause), int'(ec));
            chk("R8", "wake_req vs model", int'(wake_req), int'(ew));
            chk("R9", "resume_full vs model", int'(resume_full), int'(ef));
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic clr_all();
        step(); cause_clr = '1;
        step(); cause_clr = '0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "cause in reset", int'(cause), 0);
        chk("R1", "wake_req in reset", int'(wake_req), 0);
        chk("R1", "resume_full in reset", int'(resume_full), 0);
        step(); rst_n = 1;
        @(negedge clk);
        chk("R1", "cause after reset", int'(cause), 0);

        // R10 / R3: edge source 0, debounce 3, threshold 1
        cur_req = "R10";
        src_en = 8'h3F; src_level = '0;
        for (int i = 0; i < N; i++) begin
            db_len[i*DW +: DW] = 4'd3;
            qual_thresh[i*CW +: CW] = 4'd1;
        end
        step(); step();
        wake_in[0] = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10", "cause0 before latency", int'(cause[0]), 0);
        @(posedge clk); @(negedge clk);
        chk("R10", "cause0 at latency", int'(cause[0]), 1);
        chk("R8", "wake_req raised", int'(wake_req), 1);
        chk("R9", "routine resume level", int'(resume_full), 0);

        // R7: sticky while line held; clears on W1C
        cur_req = "R7";
        repeat (5) step();
        @(negedge clk);
        chk("R7", "cause0 sticky", int'(cause[0]), 1);
        step(); cause_clr = 8'h01;
        step(); cause_clr = '0;
        @(negedge clk);
        chk("R7", "cause0 cleared", int'(cause[0]), 0);
        chk("R3", "no second edge event while held", int'(cause[0]), 0);
        step(); wake_in[0] = 0;

        // R2: 2-cycle glitch on source 1 with debounce 3
        cur_req = "R2";
        step(); wake_in[1] = 1;
        step(); step(); wake_in[1] = 0;
        repeat (6) step();
        @(negedge clk);
        chk("R2", "glitch ignored", int'(cause[1]), 0);

        // R4 / R6: level source 2 with threshold 3 and debounce 1
        cur_req = "R6";
        src_level[2] = 1; qual_thresh[2*CW +: CW] = 4'd3; db_len[2*DW +: DW] = 4'd0;
        step(); wake_in[2] = 1;
        // filt at edge 1, events on edges 2,3,4 -> cause after edge 4
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R6", "cause2 before threshold", int'(cause[2]), 0);
        @(posedge clk); @(negedge clk);
        chk("R4", "level held reaches threshold", int'(cause[2]), 1);
        cur_req = "R4";
        repeat (10) step();
        wake_in[2] = 0;
        clr_all();
        repeat (4) step();

        // R5: disabled source 3 toggled
        cur_req = "R5";
        src_en[3] = 0;
        for (int k = 0; k < 6; k++) begin
            step(); wake_in[3] = ~wake_in[3];
            repeat (4) step();
        end
        @(negedge clk);
        chk("R5", "disabled source quiet", int'(cause[3]), 0);
        src_en[3] = 1; wake_in[3] = 0;
        repeat (4) step();
        clr_all();

        // R9 / R8: urgent source 4 and routine source 5 together
        cur_req = "R9";
        src_urgent = 8'h10;
        step(); wake_in[4] = 1; wake_in[5] = 1;
        repeat (5) step();
        @(negedge clk);
        chk("R8", "both recorded", int'(cause[5:4]), 3);
        chk("R9", "urgent gives full resume", int'(resume_full), 1);
        step(); cause_clr = 8'h10;
        step(); cause_clr = '0;
        @(negedge clk);
        chk("R9", "routine only gives low power", int'(resume_full), 0);
        chk("R8", "wake stays with routine cause", int'(wake_req), 1);
        wake_in = '0;
        clr_all();

        // Randomised phase, model compared every cycle (R3 R6 R7)
        for (int blk = 0; blk < 15; blk++) begin
            cur_req = (blk % 3 == 0) ? "R3" : ((blk % 3 == 1) ? "R6" : "R7");
            src_en = 8'($urandom); src_level = 8'($urandom); src_urgent = 8'($urandom);
            for (int i = 0; i < N; i++) begin
                db_len[i*DW +: DW] = 4'($urandom_range(0, 3));
                qual_thresh[i*CW +: CW] = 4'($urandom_range(0, 3));
            end
            for (int c = 0; c < 200; c++) begin
                step();
                for (int i = 0; i < N; i++)
                    if ($urandom_range(0, 5) == 0) wake_in[i] = ~wake_in[i];
                cause_clr = ($urandom_range(0, 7) == 0) ? 8'($urandom) : '0;
            end
        end
        step(); cause_clr = '0;
        @(negedge clk);
        finish_run();
    end
endmodule